// File: doc/BRIEF.md
# Shared-Line Response Timer

This unit sits in a CPU node on a snooping bus. For every data transfer it decides whether the node drives the wired-OR shared line, and in which cycle. A transfer starts with a one-cycle send-data strobe. Its response slot is two cycles after the strobe. In that slot the node pulses the shared line for one cycle if the local cache reports that the block is valid and will stay valid there.

If any node holds the bus in a response slot, the slot comes back two cycles later. This repeats for as long as hold is seen in each slot. If the local lookup has not finished by the response slot, the unit drives the hold line itself. It keeps hold asserted until the lookup result arrives, and then answers in the next slot.

Transfers for commands this node issued get no response. Only one transfer is tracked at a time. The interface carries no data stream, so every pin is a plain level or strobe with no valid/ready handshake and no back-pressure.

Top module: `shr_resp_timer`

## Requirements
- R1: The shared output is high in a response slot only when the captured cache decision is "hit and keep". A miss decision produces no shared pulse in any slot of that transfer.
- R2: A send-data strobe with own_cmd_i high, arriving while the unit is idle, is ignored. It never causes a shared pulse or a hold assertion.
- R3: For an accepted strobe in cycle T whose decision is known by cycle T+2, shared (if due) is asserted in cycle T+2.
- R4: When the bus hold input is high during a response slot, another response slot follows exactly two cycles later. This repeats for every slot in which hold is high. Otherwise the unit returns to idle after the slot.
- R5: Shared is never high in two consecutive cycles.
- R6: If the decision is not known in a response slot, hold_o is asserted from that cycle on. It stays high in every cycle until the cycle in which lookup_ready_i is high, and it drops in that cycle.
- R7: The decision is captured from hit_keep_i in the first cycle in which lookup_ready_i is high, counting from the strobe cycle onward. Later values of hit_keep_i have no effect on that transfer's pulses.
- R8: A send-data strobe while a transfer is tracked (from the cycle after acceptance through its last slot) is ignored. In that same cycle, overlap_err_o is high for one cycle.
- R9: A synchronous active-high reset returns the unit to idle, with shared_o, hold_o and overlap_err_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| send_data_i | input | 1 | Bus send-data strobe, one cycle per transfer |
| own_cmd_i | input | 1 | Qualifies the strobe: the transfer belongs to a command this node issued |
| bus_hold_i | input | 1 | Wired-OR bus hold line, including this node's own drive |
| lookup_ready_i | input | 1 | Local cache lookup result is available this cycle |
| hit_keep_i | input | 1 | Lookup result: block valid and to remain valid in this cache |
| shared_o | output | 1 | Drive enable for the shared line |
| hold_o | output | 1 | Drive enable for the hold line |
| overlap_err_o | output | 1 | Strobe arrived while a transfer was already tracked |

## Verification
The unit is exercised with the following patterns:
- early lookups that hit, miss, or belong to this node's own command, which separate the decision gate from the slot timing;
- foreign hold in one and in two successive slots, which shows whether the repeat is re-armed for each slot;
- lookups that finish before the slot, exactly in a slot, and in a gap cycle between slots, which exposes off-by-one errors in the stall logic;
- a flipping hit_keep_i after capture, together with strobes that arrive during tracking and in the final slot, which checks the capture-once rule and the overlap flag.

A behavioural model in the bench predicts all three outputs in every cycle.

// File: rtl/shr_resp_pkg.sv
package shr_resp_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_WAIT = 2'd1,
    SEQ_SLOT = 2'd2
  } seq_state_e;
endpackage

// File: rtl/shr_slot_seq.sv
module shr_slot_seq
  import shr_resp_pkg::*;
#(
  parameter int RESP_OFFSET = 2,
  parameter int REPEAT_GAP  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic bus_hold,
  input  logic known,
  output logic busy,
  output logic in_slot,
  output logic stalled
);
  localparam int MAXD  = (RESP_OFFSET > REPEAT_GAP) ? RESP_OFFSET : REPEAT_GAP;
  localparam int CNT_W = $clog2(MAXD + 1);

  seq_state_e       st_q;
  logic [CNT_W-1:0] cnt_q;
  logic             stall_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= SEQ_IDLE;
      cnt_q <= '0;
    end else begin
      case (st_q)
        SEQ_IDLE: if (start) begin
          st_q  <= SEQ_WAIT;
          cnt_q <= CNT_W'(RESP_OFFSET - 1);
        end
        SEQ_WAIT: begin
          if (cnt_q == CNT_W'(1)) st_q <= SEQ_SLOT;
          else                    cnt_q <= cnt_q - CNT_W'(1);
        end
        SEQ_SLOT: begin
          if (bus_hold) begin
            st_q  <= SEQ_WAIT;
            cnt_q <= CNT_W'(REPEAT_GAP - 1);
          end else begin
            st_q <= SEQ_IDLE;
          end
        end
        default: st_q <= SEQ_IDLE;
      endcase
    end
  end

  // once a slot has been missed, the stall persists until the decision exists
  always_ff @(posedge clk) begin
    if (rst || st_q == SEQ_IDLE || known) stall_q <= 1'b0;
    else if (st_q == SEQ_SLOT)            stall_q <= 1'b1;
  end

  assign busy    = (st_q != SEQ_IDLE);
  assign in_slot = (st_q == SEQ_SLOT);
  assign stalled = stall_q;
endmodule

// File: rtl/shr_decision.sv
module shr_decision (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic busy,
  input  logic lookup_ready,
  input  logic hit_keep,
  output logic known,
  output logic decision
);
  logic vld_q, dec_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 1'b0;
      dec_q <= 1'b0;
    end else if (start) begin
      vld_q <= lookup_ready;
      dec_q <= hit_keep;
    end else if (busy && !vld_q && lookup_ready) begin
      vld_q <= 1'b1;
      dec_q <= hit_keep;
    end else if (!busy) begin
      vld_q <= 1'b0;
    end
  end

  // a result arriving in the current cycle is usable at once
  assign known    = vld_q | lookup_ready;
  assign decision = vld_q ? dec_q : hit_keep;
endmodule

// File: rtl/shr_resp_timer.sv
module shr_resp_timer #(
  parameter int RESP_OFFSET = 2,
  parameter int REPEAT_GAP  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic send_data_i,
  input  logic own_cmd_i,
  input  logic bus_hold_i,
  input  logic lookup_ready_i,
  input  logic hit_keep_i,
  output logic shared_o,
  output logic hold_o,
  output logic overlap_err_o
);
  logic busy, in_slot, stalled, known, decision, start;

  assign start = send_data_i && !own_cmd_i && !busy;

  shr_slot_seq #(
    .RESP_OFFSET(RESP_OFFSET),
    .REPEAT_GAP (REPEAT_GAP)
  ) u_seq (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .bus_hold(bus_hold_i),
    .known   (known),
    .busy    (busy),
    .in_slot (in_slot),
    .stalled (stalled)
  );

  shr_decision u_dec (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .busy        (busy),
    .lookup_ready(lookup_ready_i),
    .hit_keep    (hit_keep_i),
    .known       (known),
    .decision    (decision)
  );

  assign shared_o      = in_slot && known && decision;
  assign hold_o        = (in_slot || stalled) && !known;
  assign overlap_err_o = send_data_i && busy;
endmodule

// File: rtl/shr_resp_timer_chk.sv
module shr_resp_timer_chk (
  input logic clk,
  input logic rst,
  input logic send_data_i,
  input logic own_cmd_i,
  input logic bus_hold_i,
  input logic lookup_ready_i,
  input logic shared_o,
  input logic hold_o,
  input logic overlap_err_o,
  input logic busy
);
  assert_single_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    shared_o |=> !shared_o);

  assert_slot_origin_R3: assert property (@(posedge clk) disable iff (rst)
    shared_o |-> ($past(send_data_i, 2) || $past(bus_hold_i, 2)));

  assert_hold_drops_R6: assert property (@(posedge clk) disable iff (rst)
    hold_o |-> !lookup_ready_i);

  assert_err_needs_strobe_R8: assert property (@(posedge clk) disable iff (rst)
    overlap_err_o |-> send_data_i);

  assert_own_ignored_R2: assert property (@(posedge clk) disable iff (rst)
    (send_data_i && own_cmd_i && !busy) |=> !busy);

  assert_not_both_R1: assert property (@(posedge clk) disable iff (rst)
    !(shared_o && hold_o));
endmodule

bind shr_resp_timer shr_resp_timer_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .send_data_i   (send_data_i),
  .own_cmd_i     (own_cmd_i),
  .bus_hold_i    (bus_hold_i),
  .lookup_ready_i(lookup_ready_i),
  .shared_o      (shared_o),
  .hold_o        (hold_o),
  .overlap_err_o (overlap_err_o),
  .busy          (busy)
);

// File: tb/shr_resp_timer_tb.sv
`timescale 1ns/100ps
module shr_resp_timer_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic send = 1'b0, own = 1'b0, ext_hold = 1'b0, lr = 1'b0, hit = 1'b0;
  logic shared_o, hold_o, err_o, bus_hold;
  int errors = 0, checks = 0, cycles = 0;
  string req = "R9";

  always #2.5 clk = ~clk;

  assign bus_hold = ext_hold | hold_o;

  shr_resp_timer u_dut (
    .clk(clk), .rst(rst), .send_data_i(send), .own_cmd_i(own),
    .bus_hold_i(bus_hold), .lookup_ready_i(lr), .hit_keep_i(hit),
    .shared_o(shared_o), .hold_o(hold_o), .overlap_err_o(err_o)
  );

  // behavioural model
  bit m_busy = 0, m_known = 0, m_dec = 0, m_stall = 0, m_started = 0;
  int m_wait = 0;
  bit prev_shared = 0;

  function automatic bit known_now();
    return m_known || lr;
  endfunction
  function automatic bit slot_now();
    return m_busy && (m_wait == 0);
  endfunction
  function automatic bit exp_shared();
    return slot_now() && known_now() && (m_known ? m_dec : hit);
  endfunction
  function automatic bit exp_hold();
    return m_busy && (slot_now() || m_stall) && !known_now();
  endfunction
  function automatic bit exp_err();
    return send && m_busy;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_busy = 0; m_known = 0; m_stall = 0; m_wait = 0; m_started = 1;
    end else if (!m_busy) begin
      if (send && !own) begin
        m_busy = 1; m_wait = 1; m_known = lr; m_dec = hit; m_stall = 0;
      end
    end else begin
      bit kn, sl;
      kn = known_now();
      sl = slot_now();
      if (lr && !m_known) begin m_known = 1; m_dec = hit; end
      if (sl) begin
        if (!kn) m_stall = 1;
        if (bus_hold) m_wait = 1; else m_busy = 0;
      end else begin
        m_wait--;
      end
      if (kn) m_stall = 0;
    end
  end

  task automatic chk(input string what, input bit act, input bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0b expected=%0b at cycle %0d", req, what, act, exp, cycles);
    end
  endtask

  // compare every cycle shortly before the rising edge
  always @(negedge clk) begin
    #2;
    if (!rst && m_started) begin
      chk("shared", shared_o, exp_shared());
      chk("hold", hold_o, exp_hold());
      chk("overlap_err", err_o, exp_err());
      if (prev_shared && shared_o) begin
        errors++;
        $display("FAIL R5 shared wide: actual=1 expected=0");
      end
      checks++;
      prev_shared = shared_o;
    end
  end

  task automatic idle_n(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      send = 0; own = 0; ext_hold = 0; lr = 0; hit = 0;
    end
  endtask

  // one cycle of stimulus applied at the falling edge
  task automatic drive(input bit s, input bit o, input bit h, input bit l, input bit k);
    @(negedge clk);
    send = s; own = o; ext_hold = h; lr = l; hit = k;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #2;
    req = "R9";
    chk("reset shared", shared_o, 1'b0);
    chk("reset hold", hold_o, 1'b0);
    chk("reset err", err_o, 1'b0);
    @(negedge clk); rst = 0;

    req = "R3";  // early hit, answer two cycles after strobe
    drive(1, 0, 0, 1, 1); idle_n(5);
    req = "R1";  // early miss
    drive(1, 0, 0, 1, 0); idle_n(5);
    req = "R2";  // own command with hit
    drive(1, 1, 0, 1, 1); drive(0, 0, 0, 1, 1); drive(0, 0, 1, 1, 1); idle_n(4);
    req = "R4";  // foreign hold in two successive slots
    drive(1, 0, 0, 1, 1); drive(0, 0, 0, 0, 0); drive(0, 0, 1, 0, 0);
    drive(0, 0, 0, 0, 0); drive(0, 0, 1, 0, 0); idle_n(6);
    req = "R6";  // lookup lands in a gap cycle
    drive(1, 0, 0, 0, 0); drive(0, 0, 0, 0, 0); drive(0, 0, 0, 0, 0);
    drive(0, 0, 0, 0, 0); drive(0, 0, 0, 0, 0); drive(0, 0, 0, 1, 1); idle_n(6);
    req = "R6";  // lookup lands exactly in a slot
    drive(1, 0, 0, 0, 0); drive(0, 0, 0, 0, 0); drive(0, 0, 0, 0, 0);
    drive(0, 0, 0, 0, 0); drive(0, 0, 0, 1, 1); idle_n(6);
    req = "R7";  // capture once, hit flips afterwards
    drive(1, 0, 0, 0, 0); drive(0, 0, 0, 1, 1); drive(0, 0, 1, 1, 0);
    drive(0, 0, 0, 0, 0); drive(0, 0, 0, 1, 0); idle_n(5);
    req = "R7";  // captured miss, later hit ignored
    drive(1, 0, 0, 1, 0); drive(0, 0, 0, 1, 1); drive(0, 0, 1, 1, 1);
    drive(0, 0, 0, 1, 1); drive(0, 0, 0, 1, 1); idle_n(5);
    req = "R8";  // strobes while tracked, including in the last slot
    drive(1, 0, 0, 1, 1); drive(1, 0, 0, 0, 0); drive(1, 0, 0, 0, 0);
    drive(1, 0, 0, 0, 0); drive(0, 0, 0, 0, 0); idle_n(5);
    req = "R9";  // reset in the middle of a stall
    drive(1, 0, 0, 0, 0); drive(0, 0, 0, 0, 0); drive(0, 0, 0, 0, 0);
    @(negedge clk); rst = 1; #2;
    chk("mid reset hold", hold_o, 1'b1);
    @(negedge clk); #2;
    chk("after reset hold", hold_o, 1'b0);
    chk("after reset shared", shared_o, 1'b0);
    @(negedge clk); rst = 0;
    idle_n(3);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule